// File: doc/BRIEF.md
# Programmable March-Test RAM Self-Test Engine

This block tests a single-port RAM with a march algorithm that is not fixed in hardware. Software or a tester shifts a short list of command words into the block through a one-bit serial input. A shift-enable qualifies each bit. After the list is loaded, a start pulse makes the engine run every command against the RAM, in order.

Each command names three things: a walking direction, a code that selects a short sequence of reads and writes, and a data background. For every address, the engine completes the whole sequence of one command before it moves to the next address. Each read is compared against the background or its inverse. When the list runs out, the engine raises a done flag and a pass/fail flag. Both flags stay fixed until the next reset.

Top module: `mbist_prog_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, done, go, ram_we and ram_re are all 0.
- R2: A command word is 9 bits: bit 8 is the direction (1 = descending), bits 7:4 are the operation code and bits 3:0 are the background. A load shifts in exactly NCMD words on cmd_sdi, one bit per clock while cmd_shift is 1, most significant bit first. Command 0 goes first, and unused slots are loaded as all zeros.
- R3: A command whose operation code is 0 ends the program, and so does running past slot NCMD-1. An empty program therefore finishes with go = 1.
- R4: The operation codes select these step lists, where R/W is a read/write of the background and Ri/Wi uses its inverse: 1 W; 2 R; 3 R Wi; 4 R Wi Ri; 5 W R Wi Ri; 6 Ri W; 7 Ri W R; 8 Wi; 9 Ri; 10 R R; 11 R W R; 12 Ri Wi; 13 R Wi W R; 14 Ri W Wi Ri; 15 Ri W R Wi. ram_we and ram_re are never high together.
- R5: An ascending command visits the addresses 0 up to 2^AW-1, and a descending command visits them from the top down to 0. All steps of the command are applied at one address before the address moves by one.
- R6: At done, go is 0 if any read returned data different from the value it expected, and 1 otherwise.
- R7: Let the start pulse be sampled on clock edge 0. Then done first reads 1 after edge 4 + sum over the executed commands of (1 + 2^AW * (steps + 1)).
- R8: Once done is 1, done and go stay unchanged and no RAM access is issued until reset, whatever happens on cmd_shift, cmd_sdi or start.
- R9: start is honoured only after a load has ended, when cmd_shift falls. Toggling cmd_shift or cmd_sdi, or pulsing start, while a program runs changes neither the run's result nor its length.
- R10: Each write stores the background, or its inverse for a Wi step, at the current address. After a run the RAM holds exactly what the program wrote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_sdi | input | 1 | Serial command data |
| cmd_shift | input | 1 | Qualifies cmd_sdi; falling ends a load |
| start | input | 1 | Begins execution of the loaded program |
| done | output | 1 | Program finished, held until reset |
| go | output | 1 | 1 = no read mismatch, valid with done |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe (data expected one cycle later) |
| ram_rdata | input | DW | RAM read data |

## Verification
The closest coincidence is the end of a program. The compare of the very last read is still in the pipeline while the terminating command is being fetched and the final pass/fail decision is being made. It is provoked by a stuck bit at the top address that only the last read of an ascending read-only element can see. Correct handling means go comes out 0 and the cycle count is unchanged. A second overlap comes from driving cmd_shift, cmd_sdi and start in the middle of a run. The bench judges it by comparing the run's length, result and final RAM image against the values computed for an undisturbed run.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int OPW     = 4;
  localparam int MAXSTEP = 4;

  typedef struct packed {
    logic wr;
    logic inv;
  } step_t;

  typedef struct packed {
    logic [2:0]                len;
    step_t [MAXSTEP-1:0]       s;
  } seq_t;

  typedef enum logic [1:0] {
    C_IDLE, C_SHIFT, C_GET, C_APPLY
  } ctrl_st_e;

  typedef enum logic [2:0] {
    T_IDLE, T_INIT, T_IFETCH, T_EXEC, T_DFETCH, T_CMP, T_GO, T_NOGO
  } tpg_st_e;

  localparam step_t S_R  = '{wr: 1'b0, inv: 1'b0};
  localparam step_t S_RI = '{wr: 1'b0, inv: 1'b1};
  localparam step_t S_W  = '{wr: 1'b1, inv: 1'b0};
  localparam step_t S_WI = '{wr: 1'b1, inv: 1'b1};

  // step 0 is applied first
  function automatic seq_t op_decode(input logic [OPW-1:0] op);
    seq_t d;
    d.len = 3'd0;
    d.s   = '0;
    case (op)
      4'd1:  begin d.len = 3'd1; d.s[0] = S_W; end
      4'd2:  begin d.len = 3'd1; d.s[0] = S_R; end
      4'd3:  begin d.len = 3'd2; d.s[0] = S_R;  d.s[1] = S_WI; end
      4'd4:  begin d.len = 3'd3; d.s[0] = S_R;  d.s[1] = S_WI; d.s[2] = S_RI; end
      4'd5:  begin d.len = 3'd4; d.s[0] = S_W;  d.s[1] = S_R;  d.s[2] = S_WI; d.s[3] = S_RI; end
      4'd6:  begin d.len = 3'd2; d.s[0] = S_RI; d.s[1] = S_W; end
      4'd7:  begin d.len = 3'd3; d.s[0] = S_RI; d.s[1] = S_W;  d.s[2] = S_R; end
      4'd8:  begin d.len = 3'd1; d.s[0] = S_WI; end
      4'd9:  begin d.len = 3'd1; d.s[0] = S_RI; end
      4'd10: begin d.len = 3'd2; d.s[0] = S_R;  d.s[1] = S_R; end
      4'd11: begin d.len = 3'd3; d.s[0] = S_R;  d.s[1] = S_W;  d.s[2] = S_R; end
      4'd12: begin d.len = 3'd2; d.s[0] = S_RI; d.s[1] = S_WI; end
      4'd13: begin d.len = 3'd4; d.s[0] = S_R;  d.s[1] = S_WI; d.s[2] = S_W;  d.s[3] = S_R; end
      4'd14: begin d.len = 3'd4; d.s[0] = S_RI; d.s[1] = S_W;  d.s[2] = S_WI; d.s[3] = S_RI; end
      4'd15: begin d.len = 3'd4; d.s[0] = S_RI; d.s[1] = S_W;  d.s[2] = S_R;  d.s[3] = S_WI; end
      default: begin d.len = 3'd0; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mbist_cmd_store.sv
module mbist_cmd_store
  import mbist_pkg::*;
#(
  parameter int NCMD = 8,
  parameter int CW   = 9,
  parameter int PW   = $clog2(NCMD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          sdi,
  input  logic [PW-1:0] rd_idx,
  output logic [CW-1:0] rd_word
);

  localparam int TOT = NCMD * CW;
  localparam int IW  = (NCMD > 1) ? $clog2(NCMD) : 1;
  localparam logic [PW-1:0] NCMD_P = PW'(NCMD);

  logic [TOT-1:0] sr_q;
  logic [CW-1:0]  slot [NCMD];

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[TOT-2:0], sdi};
  end

  // first word shifted in ends up in the top slot
  for (genvar k = 0; k < NCMD; k++) begin : g_slot
    assign slot[k] = sr_q[(NCMD-1-k)*CW +: CW];
  end

  assign rd_word = (rd_idx < NCMD_P) ? slot[rd_idx[IW-1:0]] : '0;

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_shift,
  input  logic start,
  input  logic tpg_done,
  output logic load_en,
  output logic run_en
);

  ctrl_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      C_IDLE:  if (cmd_shift)  st_d = C_SHIFT;
               else if (start) st_d = C_GET;
      C_SHIFT: if (!cmd_shift) st_d = C_GET;
      C_GET:   if (start)      st_d = C_APPLY;
      C_APPLY: if (tpg_done)   st_d = C_IDLE;
      default:                 st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= C_IDLE;
    else     st_q <= st_d;
  end

  assign load_en = cmd_shift && ((st_q == C_IDLE) || (st_q == C_SHIFT));
  assign run_en  = (st_q == C_APPLY);

endmodule

// File: rtl/mbist_tpg.sv
module mbist_tpg
  import mbist_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DW   = 4,
  parameter int NCMD = 8,
  parameter int CW   = 1 + OPW + DW,
  parameter int PW   = $clog2(NCMD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic [CW-1:0] slot_word,
  output logic [PW-1:0] ptr,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  output logic          ram_re,
  input  logic [DW-1:0] ram_rdata,
  output logic          done,
  output logic          go
);

  localparam logic [PW-1:0] NCMD_P = PW'(NCMD);

  tpg_st_e        st_q;
  logic [PW-1:0]  ptr_q;
  logic           cdir_q;
  logic [OPW-1:0] cop_q;
  logic [DW-1:0]  cbg_q;
  logic [1:0]     step_q;
  logic [AW-1:0]  addr_q;

  logic           f_dir;
  logic [OPW-1:0] f_op;
  logic [DW-1:0]  f_bg;

  seq_t           dec;
  step_t          cur;
  logic           last_step, last_addr, exec;
  logic [DW-1:0]  pat;

  logic           v1_q, v2_q, err_q;
  logic [DW-1:0]  e1_q, e2_q;
  logic           we_q, re_q, done_q, go_q;
  logic [AW-1:0]  ra_q;
  logic [DW-1:0]  wd_q;

  assign f_dir = slot_word[CW-1];
  assign f_op  = slot_word[CW-2 -: OPW];
  assign f_bg  = slot_word[DW-1:0];

  assign dec       = op_decode(cop_q);
  assign cur       = dec.s[step_q];
  assign last_step = ({1'b0, step_q} == (dec.len - 3'd1));
  assign last_addr = cdir_q ? (addr_q == '0) : (addr_q == '1);
  assign exec      = (st_q == T_EXEC);
  assign pat       = cur.inv ? ~cbg_q : cbg_q;

  // sequencing FSM
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= T_IDLE;
      ptr_q  <= '0;
      cdir_q <= 1'b0;
      cop_q  <= '0;
      cbg_q  <= '0;
      step_q <= '0;
      addr_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      case (st_q)
        T_IDLE: if (run_en) st_q <= T_INIT;
        T_INIT: begin
          ptr_q <= '0;
          err_q <= 1'b0;
          st_q  <= T_IFETCH;
        end
        T_IFETCH: begin
          if (f_op == '0) begin
            st_q <= T_CMP;
          end else begin
            cdir_q <= f_dir;
            cop_q  <= f_op;
            cbg_q  <= f_bg;
            addr_q <= f_dir ? '1 : '0;
            step_q <= '0;
            st_q   <= T_EXEC;
          end
        end
        T_EXEC: begin
          if (last_step) st_q <= T_DFETCH;
          else           step_q <= step_q + 2'd1;
        end
        T_DFETCH: begin
          if (last_addr) begin
            ptr_q <= ptr_q + 1'b1;
            st_q  <= T_IFETCH;
          end else begin
            addr_q <= cdir_q ? (addr_q - 1'b1) : (addr_q + 1'b1);
            step_q <= '0;
            st_q   <= T_EXEC;
          end
        end
        T_CMP: begin
          if (!v1_q && !v2_q) begin
            done_q <= 1'b1;
            go_q   <= !err_q;
            st_q   <= err_q ? T_NOGO : T_GO;
          end
        end
        default: ;
      endcase
      if (v2_q && (ram_rdata != e2_q)) err_q <= 1'b1;
    end
  end

  // registered RAM strobes and two-stage expected-data pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      ra_q <= '0;
      wd_q <= '0;
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      e1_q <= '0;
      e2_q <= '0;
    end else begin
      we_q <= exec && cur.wr;
      re_q <= exec && !cur.wr;
      if (exec) begin
        ra_q <= addr_q;
        wd_q <= pat;
      end
      v1_q <= exec && !cur.wr;
      e1_q <= pat;
      v2_q <= v1_q;
      e2_q <= e1_q;
    end
  end

  assign ptr       = ptr_q;
  assign ram_addr  = ra_q;
  assign ram_wdata = wd_q;
  assign ram_we    = we_q;
  assign ram_re    = re_q;
  assign done      = done_q;
  assign go        = go_q;

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);
  assert_go_stable_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> $stable(go_q));
  assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !(we_q || re_q));
  assert_go_needs_done_R6: assert property (@(posedge clk) disable iff (rst)
    go_q |-> done_q);
  assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(we_q && re_q));
  assert_step_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    exec |-> ({1'b0, step_q} < dec.len));
  assert_ptr_bound_R3: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= NCMD_P);
  assert_addr_walk_R5: assert property (@(posedge clk) disable iff (rst)
    (exec && $past(st_q == T_DFETCH)) |->
      (cdir_q ? (addr_q == $past(addr_q) - 1'b1) : (addr_q == $past(addr_q) + 1'b1)));

endmodule

// File: rtl/mbist_prog_ctrl.sv
module mbist_prog_ctrl
  import mbist_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DW   = 4,
  parameter int NCMD = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_sdi,
  input  logic          cmd_shift,
  input  logic          start,
  output logic          done,
  output logic          go,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  output logic          ram_re,
  input  logic [DW-1:0] ram_rdata
);

  localparam int CW = 1 + OPW + DW;
  localparam int PW = $clog2(NCMD + 1);

  logic          load_en, run_en;
  logic [PW-1:0] ptr;
  logic [CW-1:0] slot_word;
  logic          done_i;

  mbist_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_shift (cmd_shift),
    .start     (start),
    .tpg_done  (done_i),
    .load_en   (load_en),
    .run_en    (run_en)
  );

  mbist_cmd_store #(.NCMD(NCMD), .CW(CW), .PW(PW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .shift_en (load_en),
    .sdi      (cmd_sdi),
    .rd_idx   (ptr),
    .rd_word  (slot_word)
  );

  mbist_tpg #(.AW(AW), .DW(DW), .NCMD(NCMD), .CW(CW), .PW(PW)) u_tpg (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .slot_word (slot_word),
    .ptr       (ptr),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_rdata (ram_rdata),
    .done      (done_i),
    .go        (go)
  );

  assign done = done_i;

endmodule

// File: tb/sim_mbist_prog_ctrl.sv
module sim_mbist_prog_ctrl;

  localparam int AW    = 4;
  localparam int DW    = 4;
  localparam int NCMD  = 8;
  localparam int CW    = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_sdi = 1'b0, cmd_shift = 1'b0, start = 1'b0;
  logic done, go, ram_we, ram_re;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata = '0;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  mbist_prog_ctrl #(.AW(AW), .DW(DW), .NCMD(NCMD)) u0 (
    .clk(clk), .rst(rst), .cmd_sdi(cmd_sdi), .cmd_shift(cmd_shift), .start(start),
    .done(done), .go(go), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_re(ram_re), .ram_rdata(ram_rdata)
  );

  // RAM model with an optional stuck bit
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] gm  [DEPTH];
  logic fill_req = 1'b0;
  logic [DW-1:0] fill_val = '0;
  logic f_en = 1'b0, f_val = 1'b0;
  int   f_addr = 0, f_bit = 0;

  function automatic logic [DW-1:0] flt(input logic [DW-1:0] d, input int a);
    logic [DW-1:0] r = d;
    if (f_en && a == f_addr) r[f_bit] = f_val;
    return r;
  endfunction

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= flt(fill_val, i);
    end else if (ram_we) begin
      mem[ram_addr] <= flt(ram_wdata, int'(ram_addr));
    end
    if (ram_re) ram_rdata <= flt(mem[ram_addr], int'(ram_addr));
  end

  // access monitor
  logic mon_clr = 1'b0;
  int   acc_cnt = 0, first_addr = -1;
  always @(posedge clk) begin
    if (mon_clr) begin
      acc_cnt <= 0;
      first_addr <= -1;
    end else if (ram_we || ram_re) begin
      if (acc_cnt == 0) first_addr <= int'(ram_addr);
      acc_cnt <= acc_cnt + 1;
    end
  end

  // program under test
  logic          p_dir [NCMD];
  logic [3:0]    p_op  [NCMD];
  logic [DW-1:0] p_bg  [NCMD];
  int            p_n = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cmd(input int k, input logic d, input int op, input logic [DW-1:0] bg);
    p_dir[k] = d;
    p_op[k]  = 4'(op);
    p_bg[k]  = bg;
  endtask

  // step lists from R4: bit i of w/iv describes step i
  task automatic get_seq(input int op, output int n, output logic [3:0] w, output logic [3:0] iv);
    case (op)
      1:  begin n = 1; w = 4'b0001; iv = 4'b0000; end
      2:  begin n = 1; w = 4'b0000; iv = 4'b0000; end
      3:  begin n = 2; w = 4'b0010; iv = 4'b0010; end
      4:  begin n = 3; w = 4'b0010; iv = 4'b0110; end
      5:  begin n = 4; w = 4'b0101; iv = 4'b1100; end
      6:  begin n = 2; w = 4'b0010; iv = 4'b0001; end
      7:  begin n = 3; w = 4'b0010; iv = 4'b0001; end
      8:  begin n = 1; w = 4'b0001; iv = 4'b0001; end
      9:  begin n = 1; w = 4'b0000; iv = 4'b0001; end
      10: begin n = 2; w = 4'b0000; iv = 4'b0000; end
      11: begin n = 3; w = 4'b0010; iv = 4'b0000; end
      12: begin n = 2; w = 4'b0010; iv = 4'b0011; end
      13: begin n = 4; w = 4'b0110; iv = 4'b0010; end
      14: begin n = 4; w = 4'b0110; iv = 4'b1101; end
      15: begin n = 4; w = 4'b1010; iv = 4'b1001; end
      default: begin n = 0; w = 4'b0000; iv = 4'b0000; end
    endcase
  endtask

  task automatic gold_run(output int exp_t, output int exp_go);
    int t = 0;
    int mis = 0;
    for (int i = 0; i < DEPTH; i++) gm[i] = flt(fill_val, i);
    for (int k = 0; k < p_n; k++) begin
      int n;
      logic [3:0] w, iv;
      get_seq(int'(p_op[k]), n, w, iv);
      t += 1 + DEPTH * (n + 1);
      for (int j = 0; j < DEPTH; j++) begin
        int a = p_dir[k] ? (DEPTH - 1 - j) : j;
        for (int s = 0; s < n; s++) begin
          logic [DW-1:0] pv = iv[s] ? ~p_bg[k] : p_bg[k];
          if (w[s]) gm[a] = flt(pv, a);
          else if (gm[a] != pv) mis++;
        end
      end
    end
    exp_t  = 4 + t;
    exp_go = (mis == 0) ? 1 : 0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic fill(input logic [DW-1:0] v);
    @(negedge clk);
    fill_req = 1'b1;
    fill_val = v;
    @(negedge clk) fill_req = 1'b0;
  endtask

  task automatic load_prog();
    for (int k = 0; k < NCMD; k++) begin
      logic [CW-1:0] word = (k < p_n) ? {p_dir[k], p_op[k], p_bg[k]} : '0;
      for (int b = CW - 1; b >= 0; b--) begin
        @(negedge clk);
        cmd_shift = 1'b1;
        cmd_sdi = word[b];
      end
    end
    @(negedge clk);
    cmd_shift = 1'b0;
    cmd_sdi = 1'b0;
    @(posedge clk);
  endtask

  task automatic exec_run(output int n);
    @(negedge clk);
    start = 1'b1;
    mon_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    mon_clr = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic disturb();
    repeat (8) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cmd_shift = ~cmd_shift;
      cmd_sdi = i[0];
      start = i[1];
    end
    @(negedge clk);
    cmd_shift = 1'b0;
    cmd_sdi = 1'b0;
    start = 1'b0;
  endtask

  task automatic full_run(input string tag, input logic [DW-1:0] fv, input bit poke);
    int et, eg, n, mis;
    do_reset();
    fill(fv);
    load_prog();
    gold_run(et, eg);
    if (poke) fork exec_run(n); disturb(); join
    else exec_run(n);
    check({tag, " R7 R2 cycles to done"}, n, et);
    check({tag, " R6 go"}, int'(go), eg);
    mis = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== gm[i]) mis++;
    check({tag, " R10 R4 RAM image mismatches"}, mis, 0);
  endtask

  task automatic set_marchc(input logic [DW-1:0] bg);
    p_n = 6;
    set_cmd(0, 1'b0, 1, bg);
    set_cmd(1, 1'b0, 3, bg);
    set_cmd(2, 1'b0, 6, bg);
    set_cmd(3, 1'b1, 3, bg);
    set_cmd(4, 1'b1, 6, bg);
    set_cmd(5, 1'b0, 2, bg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 done after reset", int'(done), 0);
    check("R1 go after reset", int'(go), 0);
    check("R1 ram strobes after reset", int'(ram_we) + int'(ram_re), 0);

    // R3 empty program
    p_n = 0;
    full_run("R3 empty program", 4'h5, 1'b0);
    check("R3 empty program go", int'(go), 1);

    // R4 sweep of every operation code behind an ascending W
    for (int op = 1; op < 16; op++) begin
      p_n = 2;
      set_cmd(0, 1'b0, 1, 4'b0110);
      set_cmd(1, op[0], op, op[1] ? 4'b0110 : 4'b1001);
      full_run($sformatf("R4 op %0d", op), 4'b0011, 1'b0);
      check($sformatf("R5 op %0d first address", op), first_addr, 0);
    end

    // R5 descending walk
    p_n = 1;
    set_cmd(0, 1'b1, 1, 4'b1010);
    full_run("R5 descending write", 4'b0000, 1'b0);
    check("R5 descending first address", first_addr, DEPTH - 1);

    // march element sequence, clean and faulty
    set_marchc(4'b0000);
    full_run("R6 march clean bg0", 4'b1111, 1'b0);
    check("R6 march clean bg0 pass", int'(go), 1);
    set_marchc(4'b0101);
    full_run("R6 march clean bg5", 4'b1111, 1'b0);
    f_en = 1'b1; f_addr = 7; f_bit = 2; f_val = 1'b0;
    set_marchc(4'b0000);
    full_run("R6 march stuck0", 4'b1111, 1'b0);
    check("R6 march stuck0 fail", int'(go), 0);

    // only the final read of the program can see this fault
    f_addr = DEPTH - 1; f_bit = 1; f_val = 1'b1;
    p_n = 2;
    set_cmd(0, 1'b0, 1, 4'b0101);
    set_cmd(1, 1'b0, 2, 4'b0101);
    full_run("R6 last read fault", 4'b0101, 1'b0);
    check("R6 last read fault fail", int'(go), 0);
    f_en = 1'b0;

    // R3 all slots used, no terminator
    p_n = 8;
    set_cmd(0, 1'b0, 1, 4'b1100);
    set_cmd(1, 1'b1, 3, 4'b1100);
    set_cmd(2, 1'b0, 6, 4'b1100);
    set_cmd(3, 1'b1, 4, 4'b1100);
    set_cmd(4, 1'b0, 10, 4'b0011);
    set_cmd(5, 1'b1, 3, 4'b0011);
    set_cmd(6, 1'b0, 7, 4'b0011);
    set_cmd(7, 1'b1, 11, 4'b1100);
    full_run("R3 eight commands", 4'b0000, 1'b0);

    // R8 results frozen after done
    begin
      int go_snap = int'(go);
      @(negedge clk) mon_clr = 1'b1;
      @(negedge clk) mon_clr = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        cmd_shift = i[0];
        cmd_sdi = 1'b1;
        start = i[1];
      end
      @(negedge clk);
      cmd_shift = 1'b0;
      start = 1'b0;
      repeat (6) @(negedge clk);
      check("R8 done held", int'(done), 1);
      check("R8 go held", int'(go), go_snap);
      check("R8 no RAM access after done", acc_cnt, 0);
    end

    // R9 stray shift/start traffic during a run
    set_marchc(4'b0011);
    full_run("R9 disturbed clean", 4'b1010, 1'b1);
    f_en = 1'b1; f_addr = 3; f_bit = 0; f_val = 1'b1;
    full_run("R9 disturbed faulty", 4'b1010, 1'b1);
    check("R9 disturbed faulty fail", int'(go), 0);
    f_en = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule